// File: doc/BRIEF.md
# Interconnect Performance Counter Bank

This block watches a bus interconnect and counts what happens in it. It has five 32-bit counters. Slot 0 counts clock cycles and has no event choice. Slots 1 to 4 each count one event, chosen from a 256-wide vector of single-cycle event pulses. That vector is organised as eight source ports with 32 event codes each. A master enable in a global control word gates all counting. Each counter also has its own enable. When a counter wraps, it latches a sticky overflow flag, and that flag drives the counter's own interrupt line.

Software reaches the bank through a single-cycle register port. A write is applied at the clock edge. The read data is a combinational function of the address and the current state. Address bit 16 selects the counter region; when that bit is clear, the address falls in the control region. In the counter region, each counter owns a 4 KB page.

Top module: `icpc_bank`

## Requirements
- R1: After reset every counter, selector, enable and flag reads zero. The control word at control offset 0x100 reads 0x2000, meaning zero in bit 0 and four programmable counters in bits 15:11. The identity word at control offset 0xFE8 reads the revision parameter in bits 7:4, which is 0x10 by default.
- R2: Counter 0 adds one on every cycle in which the master enable (control bit 0) and its own enable are both set. It does not depend on its selector or on the event inputs.
- R3: Counter n (1 to 4) adds one in a cycle where both enables are set and bit `sel` of the event vector is high. Here `sel` is the counter's 8-bit selector: bits 7:5 give the port and bits 4:0 give the code, so the bit index equals the selector value.
- R4: A counter holds its value in any cycle where the master enable or its own enable (page offset 0x8, bit 0) is clear.
- R5: A count of 0xFFFFFFFF that is incremented becomes 0 and sets bit 0 of the counter's overflow word (page offset 0xC).
- R6: Writing 1 to overflow bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap happens in the same cycle as a clear, the flag stays set.
- R7: `irq_o[n]` follows counter n's overflow flag and no other counter's flag.
- R8: A write to the count word (offset 0x4) loads the counter. If an increment falls in the same cycle, the loaded value wins.
- R9: Counter n's page starts at counter-region address n*0x1000. Inside the page, offset 0x0 holds the selector, 0x4 the count, 0x8 the enable and 0xC the overflow flag, and each page is independent of the others.
- R10: Reads of unmapped addresses (pages 5 to 15, other page offsets, other control offsets) return 0, and writes to them change nothing.
- R11: Bits 15:11 of the control word are read-only; only bit 0 is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_addr | input | 17 | Byte address; bit 16 selects the counter region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 256 | Event pulses, bit index = port*32 + code |
| irq_o | output | 5 | Per-counter overflow interrupt |

## Verification
Two functions can land in one cycle: a software write to a counter and that counter's own update. The first collision is a count load against an event increment. The second is a write-1 clear of the overflow flag in the same cycle that the counter wraps. The bench forces both collisions with directed cycles, holding the selected event bit high while the write happens, and expects the loaded value and a flag that stays set. It then runs random register traffic against random event vectors, so that writes and increments keep colliding, and judges every read against a reference model.

// File: rtl/icpc_pkg.sv
package icpc_pkg;
    localparam int CNT_W  = 32;
    localparam int SEL_W  = 8;
    localparam int NPORT  = 8;
    localparam int NCODE  = 32;
    localparam int EVT_W  = NPORT * NCODE;

    localparam logic [11:0] PG_SEL = 12'h000;
    localparam logic [11:0] PG_CNT = 12'h004;
    localparam logic [11:0] PG_EN  = 12'h008;
    localparam logic [11:0] PG_OVF = 12'h00C;
    localparam logic [15:0] CR_CTRL = 16'h0100;
    localparam logic [15:0] CR_ID   = 16'h0FE8;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             ovf;
    } ctr_state_t;
endpackage

// File: rtl/icpc_evt_mux.sv
module icpc_evt_mux
    import icpc_pkg::*;
(
    input  logic [EVT_W-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    // selector bits 7:5 = port, 4:0 = code, so the flat index is the selector
    assign hit = evt[sel];
endmodule

// File: rtl/icpc_counter.sv
module icpc_counter
    import icpc_pkg::*;
#(
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             evt_hit,
    input  logic             wr_sel,
    input  logic             wr_cnt,
    input  logic             wr_en,
    input  logic             wr_ovf,
    input  logic [CNT_W-1:0] wdata,
    output ctr_state_t       st_q
);
    ctr_state_t st_d;
    logic       inc;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        inc  = gen_en && st_q.en && (IS_CYCLE || evt_hit);
        wrap = inc && (&st_q.cnt) && !wr_cnt;
        if (wr_sel) st_d.sel = wdata[SEL_W-1:0];
        if (wr_en)  st_d.en  = wdata[0];
        if (wr_cnt)   st_d.cnt = wdata;
        else if (inc) st_d.cnt = st_q.cnt + 1'b1;
        if (wr_ovf && wdata[0]) st_d.ovf = 1'b0;
        if (wrap)               st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> st_q.cnt == $past(wdata));
    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_cnt && (st_q.cnt == '1)) |=> (st_q.ovf && st_q.cnt == '0));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(gen_en && st_q.en) && !wr_cnt) |=> $stable(st_q.cnt));
    // R6
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovf && wdata[0] && !(inc && !wr_cnt && st_q.cnt == '1)) |=> !st_q.ovf);
endmodule

// File: rtl/icpc_bank.sv
module icpc_bank
    import icpc_pkg::*;
#(
    parameter int          NUM_EVT = 4,
    parameter logic [3:0]  REV     = 4'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [16:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [EVT_W-1:0] evt_i,
    output logic [NUM_EVT:0] irq_o
);
    localparam int NUM_CNT = NUM_EVT + 1;
    localparam logic [4:0] NCNT_F = 5'(NUM_EVT);

    logic       gen_d, gen_q;
    logic       in_ctr;
    logic [3:0] page;
    logic [11:0] off;
    ctr_state_t st [NUM_CNT];

    assign in_ctr = reg_addr[16];
    assign page   = reg_addr[15:12];
    assign off    = reg_addr[11:0];

    always_comb begin
        gen_d = gen_q;
        if (reg_wr && !in_ctr && reg_addr[15:0] == CR_CTRL) gen_d = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= 1'b0;
        else        gen_q <= gen_d;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
        logic hit;
        logic pg_wr;
        assign pg_wr = reg_wr && in_ctr && (page == 4'(i));
        if (i == 0) begin : g_cyc
            assign hit = 1'b1;
        end else begin : g_evt
            icpc_evt_mux u_mux (.evt(evt_i), .sel(st[i].sel), .hit(hit));
        end
        icpc_counter #(.IS_CYCLE(i == 0)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .gen_en (gen_q),
            .evt_hit(hit),
            .wr_sel (pg_wr && off == PG_SEL),
            .wr_cnt (pg_wr && off == PG_CNT),
            .wr_en  (pg_wr && off == PG_EN),
            .wr_ovf (pg_wr && off == PG_OVF),
            .wdata  (reg_wdata),
            .st_q   (st[i])
        );
        assign irq_o[i] = st[i].ovf;
    end

    always_comb begin
        reg_rdata = '0;
        if (!in_ctr) begin
            if (reg_addr[15:0] == CR_CTRL)    reg_rdata = {16'b0, NCNT_F, 10'b0, gen_q};
            else if (reg_addr[15:0] == CR_ID) reg_rdata = {24'b0, REV, 4'b0};
        end else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (page == 4'(k)) begin
                    case (off)
                        PG_SEL:  reg_rdata = {24'b0, st[k].sel};
                        PG_CNT:  reg_rdata = st[k].cnt;
                        PG_EN:   reg_rdata = {31'b0, st[k].en};
                        PG_OVF:  reg_rdata = {31'b0, st[k].ovf};
                        default: reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ctr && page >= 4'(NUM_CNT)) |-> reg_rdata == '0);
    // R11
    ctrl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ctr && reg_addr[15:0] == CR_CTRL) |-> reg_rdata[15:11] == NCNT_F);
endmodule

// File: tb/icpc_bank_bench.sv
module icpc_bank_bench;
    localparam int NC = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [16:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] evt_i = '0;
    logic [4:0]   irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  m_sel [NC];
    logic [31:0] m_cnt [NC];
    logic        m_en  [NC];
    logic        m_ovf [NC];
    logic        m_gen;

    always #2.5 clk = ~clk;

    icpc_bank u_icpc_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    // reference model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_gen <= 1'b0;
            for (int i = 0; i < NC; i++) begin
                m_sel[i] <= '0; m_cnt[i] <= '0; m_en[i] <= 1'b0; m_ovf[i] <= 1'b0;
            end
        end else begin
            if (reg_wr && reg_addr == 17'h00100) m_gen <= reg_wdata[0];
            for (int i = 0; i < NC; i++) begin
                logic up, pw, f;
                logic [31:0] c;
                up = m_gen && m_en[i] && (i == 0 || evt_i[m_sel[i]]);
                pw = reg_wr && reg_addr[16] && reg_addr[15:12] == 4'(i);
                c = m_cnt[i];
                f = m_ovf[i];
                if (pw && reg_addr[11:0] == 12'h004) c = reg_wdata;
                else if (up) begin
                    c = m_cnt[i] + 1;
                    if (m_cnt[i] == 32'hFFFF_FFFF) f = 1'b1;
                end
                if (pw && reg_addr[11:0] == 12'h00C && reg_wdata[0] && !(up && m_cnt[i] == 32'hFFFF_FFFF && c == 0))
                    f = 1'b0;
                m_cnt[i] <= c;
                m_ovf[i] <= f;
                if (pw && reg_addr[11:0] == 12'h000) m_sel[i] <= reg_wdata[7:0];
                if (pw && reg_addr[11:0] == 12'h008) m_en[i] <= reg_wdata[0];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [16:0] a);
        int p;
        if (!a[16]) begin
            if (a[15:0] == 16'h0100) return 32'h2000 | {31'b0, m_gen};
            if (a[15:0] == 16'h0FE8) return 32'h10;
            return 0;
        end
        p = int'(a[15:12]);
        if (p >= NC) return 0;
        case (a[11:0])
            12'h000: return {24'b0, m_sel[p]};
            12'h004: return m_cnt[p];
            12'h008: return {31'b0, m_en[p]};
            12'h00C: return {31'b0, m_ovf[p]};
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [16:0] a);
        if (!a[16]) return (a[15:0] == 16'h0100) ? "R11" : (a[15:0] == 16'h0FE8) ? "R1" : "R10";
        if (int'(a[15:12]) >= NC) return "R10";
        case (a[11:0])
            12'h004: return "R3";
            12'h00C: return "R6";
            12'h000, 12'h008: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle; compares the read port and interrupts against the model afterwards
    task automatic cyc(input logic wr, input logic [16:0] a, input logic [31:0] d, input logic [255:0] e);
        logic [4:0] mi;
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = e;
        @(posedge clk);
        @(negedge clk);
        chk(tag_of(a), reg_rdata, m_read(a));
        for (int i = 0; i < NC; i++) mi[i] = m_ovf[i];
        chk("R7", {27'b0, irq_o}, {27'b0, mi});
    endtask

    function automatic logic [255:0] one(input int b);
        logic [255:0] v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] e69;
        e69 = one(69);               // port 2, code 5 -> selector 0x45
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", reg_rdata, 32'h0);               // addr 0 in control region
        cyc(0, 17'h00100, 0, '0); chk("R1", reg_rdata, 32'h2000);
        cyc(0, 17'h00FE8, 0, '0); chk("R1", reg_rdata, 32'h10);
        cyc(0, 17'h11004, 0, '0); chk("R1", reg_rdata, 32'h0);
        chk("R1", {27'b0, irq_o}, 32'h0);
        // R11 only bit 0 writable
        cyc(1, 17'h00100, 32'hFFFF_FFFF, '0); chk("R11", reg_rdata, 32'h2001);
        // R2 cycle counter ignores selector and events
        cyc(1, 17'h10000, 32'h45, '0);
        cyc(1, 17'h10008, 32'h1, '0);
        cyc(0, 17'h10004, 0, '0); chk("R2", reg_rdata, 32'd1);
        cyc(0, 17'h10004, 0, '0); chk("R2", reg_rdata, 32'd2);
        // R3 event counter
        cyc(1, 17'h11000, 32'h45, '0);
        cyc(1, 17'h11008, 32'h1, '0);
        cyc(0, 17'h11004, 0, e69); chk("R3", reg_rdata, 32'd1);
        cyc(0, 17'h11004, 0, e69); chk("R3", reg_rdata, 32'd2);
        cyc(0, 17'h11004, 0, one(70)); chk("R3", reg_rdata, 32'd2);
        cyc(0, 17'h11004, 0, one(5));  chk("R3", reg_rdata, 32'd2);
        // R4 either enable off holds the count
        cyc(1, 17'h00100, 32'h0, '0);
        cyc(0, 17'h11004, 0, e69); chk("R4", reg_rdata, 32'd2);
        cyc(1, 17'h00100, 32'h1, '0);
        cyc(1, 17'h11008, 32'h0, '0);
        cyc(0, 17'h11004, 0, e69); chk("R4", reg_rdata, 32'd2);
        cyc(1, 17'h11008, 32'h1, '0);
        // R5 wrap
        cyc(1, 17'h11004, 32'hFFFF_FFFE, '0);
        cyc(0, 17'h1100C, 0, e69); chk("R5", reg_rdata, 32'd0);
        cyc(0, 17'h11004, 0, e69); chk("R5", reg_rdata, 32'd0);
        cyc(0, 17'h1100C, 0, '0);  chk("R5", reg_rdata, 32'd1);
        chk("R7", {27'b0, irq_o}, 32'b00010);
        // R6 clear semantics
        cyc(1, 17'h1100C, 32'h0, '0); chk("R6", reg_rdata, 32'd1);
        cyc(1, 17'h1100C, 32'h1, '0); chk("R6", reg_rdata, 32'd0);
        cyc(1, 17'h11004, 32'hFFFF_FFFF, '0);
        cyc(1, 17'h1100C, 32'h1, e69); chk("R6", reg_rdata, 32'd1);
        // R8 load beats increment
        cyc(1, 17'h11004, 32'h1234, e69); chk("R8", reg_rdata, 32'h1234);
        // R10 unmapped
        cyc(1, 17'h15004, 32'h5, '0);  chk("R10", reg_rdata, 32'h0);
        cyc(1, 17'h11010, 32'h7, e69); chk("R10", reg_rdata, 32'h0);
        cyc(0, 17'h00104, 0, '0);      chk("R10", reg_rdata, 32'h0);
        // R9 page independence
        cyc(1, 17'h14000, 32'hE1, '0); chk("R9", reg_rdata, 32'hE1);
        cyc(0, 17'h13000, 0, '0);      chk("R9", reg_rdata, 32'h0);

        // random traffic against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [16:0] a;
            logic [31:0] d;
            logic [255:0] e;
            logic w;
            for (int k = 0; k < 8; k++) e[k*32 +: 32] = $urandom;
            case ($urandom % 10)
                0: a = 17'h00100;
                1: a = 17'h00FE8;
                2: a = 17'h00200;
                default: begin
                    logic [11:0] o;
                    case ($urandom % 5)
                        0: o = 12'h000; 1: o = 12'h004; 2: o = 12'h008;
                        3: o = 12'h00C; default: o = 12'h010;
                    endcase
                    a = {1'b1, 4'($urandom % 7), o};
                end
            endcase
            w = ($urandom % 3) == 0;
            d = $urandom;
            if (a == 17'h00100 || a[11:0] == 12'h008) d[0] = ($urandom % 4) != 0;
            if (a[11:0] == 12'h004 && a[16] && ($urandom % 2)) d = 32'hFFFF_FFF0 | 32'($urandom % 16);
            cyc(w, a, d, e);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule